// File: doc/BRIEF.md
# Multi-Channel Converter Update Sequencer

This block sits on the bus side of a group of double-buffered digital-to-analog converters and generates their control lines. Each converter has its own active-low chip select; all of them share one data bus, one first-stage write strobe, one second-stage write strobe, one transfer line and one latch-enable line. A host asks for a per-channel load, and the sequencer places the word on the bus, selects that one channel and pulses the first-stage strobe. The host then asks for a commit. The sequencer selects every channel, drops the transfer line and pulses the second-stage strobe, so every converter updates its output at the same instant.

All timing is counted in clock cycles. Parameters set the setup lead before a strobe, the minimum strobe low width and the hold time after the latching rising edge. The sequencer keeps a mask of channels loaded since the last commit. A freeze input pulls latch enable low and stalls the sequencer in place. Requests that arrive while the sequencer is busy or frozen wait in a small in-order queue.

Top module: `dac_update_seq`

## Requirements
- R1: After reset all chip selects, both write strobes and the transfer line are high, latch enable is high, the data bus is zero, and busy, done and the dirty mask are all zero.
- R2: A load for channel c places the data on the bus and drives only cs_n bit c low (bit i selects channel i). wr1_n, wr2_n and xfer_n stay high for SU_CYC cycles before wr1_n falls.
- R3: Without freeze, each wr1_n or wr2_n low pulse lasts exactly STROBE_CYC cycles and never less.
- R4: After a strobe rises, the chip selects and the data bus hold their values for HOLD_CYC more cycles before every chip select returns high.
- R5: A commit drives every cs_n bit low and xfer_n low with wr1_n high for SU_CYC cycles. It then pulses wr2_n low for STROBE_CYC cycles and holds HOLD_CYC cycles before releasing.
- R6: Dirty-mask bit c sets at the end of a load for channel c. The whole mask clears on the edge that ends a commit, and done is high for exactly that one cycle.
- R7: A commit with an empty dirty mask still produces the full transfer pulse and then the done pulse.
- R8: While freeze is high, latch enable is low from the next cycle on. No strobe, chip select or data value changes, and no new sequence starts. Requests still enter the queue, and a stalled strobe lengthens by the number of frozen cycles.
- R9: Requests are served strictly in arrival order. A load and a commit requested in the same cycle are queued load first, so that commit includes that load.
- R10: The queue holds QDEPTH requests. A request that arrives while the queue is full is discarded.
- R11: While idle, all active-low lines rest high. The data bus changes only in a cycle that follows one with every chip select high, and only while both strobes are high.
- R12: busy is high from the cycle after a request until the sequencer is idle with an empty queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze | input | 1 | Holds all outputs and forces latch enable low |
| wr_req | input | 1 | Request to load one channel |
| wr_chan | input | CHW | Channel index for wr_req |
| wr_data | input | DW | Word to load |
| commit_req | input | 1 | Request a simultaneous transfer |
| busy | output | 1 | Sequence running or requests pending |
| done | output | 1 | One-cycle pulse at commit completion |
| dirty | output | NCH | Channels loaded since the last commit |
| dbus | output | DW | Shared converter data bus |
| cs_n | output | NCH | Per-channel active-low chip selects |
| wr1_n | output | 1 | Shared first-stage write strobe, active low |
| wr2_n | output | 1 | Shared second-stage write strobe, active low |
| xfer_n | output | 1 | Shared transfer line, active low |
| ile | output | 1 | Shared latch enable, active high |

## Verification
Two events can coincide: a load request and a commit request in the same cycle, and a freeze that lands while a strobe is already low. The bench raises wr_req and commit_req on the same clock edge. It then checks that the logged pulse order is the load pulse followed by the transfer pulse, and that the mask is empty when done fires. It also asserts freeze on the first cycle wr1_n is seen low. It expects the strobe width to grow by exactly the number of frozen cycles and latch enable to stay low throughout.

// File: rtl/dus_pkg.sv
package dus_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;
endpackage

// File: rtl/dus_req_queue.sv
module dus_req_queue #(
    parameter int W     = 10,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_a,
    input  logic [W-1:0] din_a,
    input  logic         push_b,
    input  logic [W-1:0] din_b,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } qstate_t;

    qstate_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic acc_a, acc_b;
    logic [AW-1:0] wa, wb;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d     = q;
        acc_a = push_a && (int'(q.cnt) < DEPTH);
        acc_b = push_b && ((int'(q.cnt) + int'(acc_a)) < DEPTH);
        wa    = q.wr;
        wb    = acc_a ? step(q.wr) : q.wr;
        if (acc_b)      d.wr = step(wb);
        else if (acc_a) d.wr = wb;
        if (pop)        d.rd = step(q.rd);
        d.cnt = q.cnt + CW'(acc_a) + CW'(acc_b) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (acc_a) mem[wa] <= din_a;
        if (acc_b) mem[wb] <= din_b;
    end

    assign dout  = mem[q.rd];
    assign empty = (q.cnt == '0);
endmodule

// File: rtl/dus_phase_timer.sv
module dus_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          stall,
    output logic          expired
);
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                        cnt_d = load_val;
        else if (!stall && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dac_update_seq.sv
module dac_update_seq
    import dus_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int DW         = 8,
    parameter int QDEPTH     = 4,
    parameter int SU_CYC     = 1,
    parameter int STROBE_CYC = 113,
    parameter int HOLD_CYC   = 7,
    localparam int CHW       = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           freeze,
    input  logic           wr_req,
    input  logic [CHW-1:0] wr_chan,
    input  logic [DW-1:0]  wr_data,
    input  logic           commit_req,
    output logic           busy,
    output logic           done,
    output logic [NCH-1:0] dirty,
    output logic [DW-1:0]  dbus,
    output logic [NCH-1:0] cs_n,
    output logic           wr1_n,
    output logic           wr2_n,
    output logic           xfer_n,
    output logic           ile
);
    localparam int EW   = 1 + CHW + DW;
    localparam int MAXA = (SU_CYC > HOLD_CYC) ? SU_CYC : HOLD_CYC;
    localparam int MAXC = (STROBE_CYC > MAXA) ? STROBE_CYC : MAXA;
    localparam int TW   = $clog2(MAXC + 1);

    typedef struct packed {
        phase_e         phase;
        logic           commit;
        logic [CHW-1:0] ch;
        logic [DW-1:0]  dbus;
        logic [NCH-1:0] cs_n;
        logic           wr1_n;
        logic           wr2_n;
        logic           xfer_n;
        logic           ile;
        logic [NCH-1:0] dirty;
        logic           done;
    } seq_t;

    seq_t q, d;

    logic [EW-1:0]  head;
    logic           q_empty;
    logic           pop;
    logic           t_load;
    logic [TW-1:0]  t_val;
    logic           t_exp;
    logic           head_commit;
    logic [CHW-1:0] head_ch;
    logic [DW-1:0]  head_data;

    dus_req_queue #(.W(EW), .DEPTH(QDEPTH)) u_queue (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_a (wr_req),
        .din_a  ({1'b0, wr_chan, wr_data}),
        .push_b (commit_req),
        .din_b  ({1'b1, {CHW{1'b0}}, {DW{1'b0}}}),
        .pop    (pop),
        .dout   (head),
        .empty  (q_empty)
    );

    dus_phase_timer #(.CW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .stall    (freeze),
        .expired  (t_exp)
    );

    assign {head_commit, head_ch, head_data} = head;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.ile  = !freeze;
        pop    = 1'b0;
        t_load = 1'b0;
        t_val  = '0;
        if (!freeze) begin
            unique case (q.phase)
                PH_IDLE: begin
                    if (!q_empty) begin
                        pop      = 1'b1;
                        t_load   = 1'b1;
                        t_val    = TW'(SU_CYC - 1);
                        d.phase  = PH_SETUP;
                        d.commit = head_commit;
                        d.ch     = head_ch;
                        if (head_commit) begin
                            d.cs_n   = '0;
                            d.xfer_n = 1'b0;
                        end else begin
                            d.dbus = head_data;
                            d.cs_n = ~(NCH'(1) << head_ch);
                        end
                    end
                end
                PH_SETUP: begin
                    if (t_exp) begin
                        t_load  = 1'b1;
                        t_val   = TW'(STROBE_CYC - 1);
                        d.phase = PH_STROBE;
                        if (q.commit) d.wr2_n = 1'b0;
                        else          d.wr1_n = 1'b0;
                    end
                end
                PH_STROBE: begin
                    if (t_exp) begin
                        t_load  = 1'b1;
                        t_val   = TW'(HOLD_CYC - 1);
                        d.phase = PH_HOLD;
                        d.wr1_n = 1'b1;
                        d.wr2_n = 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (t_exp) begin
                        d.phase  = PH_IDLE;
                        d.cs_n   = '1;
                        d.xfer_n = 1'b1;
                        if (q.commit) begin
                            d.dirty = '0;
                            d.done  = 1'b1;
                        end else begin
                            d.dirty[q.ch] = 1'b1;
                        end
                    end
                end
                default: d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.phase  <= PH_IDLE;
            q.cs_n   <= '1;
            q.wr1_n  <= 1'b1;
            q.wr2_n  <= 1'b1;
            q.xfer_n <= 1'b1;
            q.ile    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy   = (q.phase != PH_IDLE) || !q_empty;
    assign done   = q.done;
    assign dirty  = q.dirty;
    assign dbus   = q.dbus;
    assign cs_n   = q.cs_n;
    assign wr1_n  = q.wr1_n;
    assign wr2_n  = q.wr2_n;
    assign xfer_n = q.xfer_n;
    assign ile    = q.ile;
endmodule

// File: rtl/dus_checker.sv
module dus_checker #(
    parameter int NCH        = 4,
    parameter int DW         = 8,
    parameter int STROBE_CYC = 113
) (
    input logic           clk,
    input logic           rst_n,
    input logic           freeze,
    input logic           busy,
    input logic           done,
    input logic [NCH-1:0] dirty,
    input logic [DW-1:0]  dbus,
    input logic [NCH-1:0] cs_n,
    input logic           wr1_n,
    input logic           wr2_n,
    input logic           xfer_n,
    input logic           ile
);
    int low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                low_cnt <= 0;
        else if (!wr1_n || !wr2_n) low_cnt <= low_cnt + 1;
        else                       low_cnt <= 0;
    end

    a_r11_idle_rest: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&cs_n && wr1_n && wr2_n && xfer_n));

    a_r2_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        !wr1_n |-> ($countones(~cs_n) == 1 && xfer_n && wr2_n));

    a_r3_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        (wr1_n && wr2_n && low_cnt != 0) |-> (low_cnt >= STROBE_CYC));

    a_r5_commit_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !wr2_n |-> (cs_n == '0 && !xfer_n && wr1_n));

    a_r11_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dbus) |-> ($past(&cs_n) && wr1_n && wr2_n));

    a_r8_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> ($stable(cs_n) && $stable(wr1_n) && $stable(wr2_n) && $stable(dbus) && !ile));

    a_r6_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dirty == '0 && xfer_n));

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind dac_update_seq dus_checker #(
    .NCH(NCH), .DW(DW), .STROBE_CYC(STROBE_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .busy(busy), .done(done),
    .dirty(dirty), .dbus(dbus), .cs_n(cs_n), .wr1_n(wr1_n), .wr2_n(wr2_n),
    .xfer_n(xfer_n), .ile(ile)
);

// File: tb/tb_dac_update_seq.sv
module tb_dac_update_seq;
    localparam int NCH = 4, DW = 8, QD = 4, SU = 1, SW = 113, HD = 7;

    logic clk = 1'b0, rst_n = 1'b0, freeze = 1'b0;
    logic wr_req = 1'b0, commit_req = 1'b0;
    logic [1:0] wr_chan = '0;
    logic [DW-1:0] wr_data = '0;
    logic busy, done, wr1_n, wr2_n, xfer_n, ile;
    logic [NCH-1:0] dirty, cs_n;
    logic [DW-1:0] dbus;

    int checks = 0, fails = 0;
    bit fin = 1'b0;

    always #4 clk = ~clk;

    dac_update_seq #(.NCH(NCH), .DW(DW), .QDEPTH(QD), .SU_CYC(SU),
                     .STROBE_CYC(SW), .HOLD_CYC(HD)) dut (
        .clk(clk), .rst_n(rst_n), .freeze(freeze), .wr_req(wr_req),
        .wr_chan(wr_chan), .wr_data(wr_data), .commit_req(commit_req),
        .busy(busy), .done(done), .dirty(dirty), .dbus(dbus), .cs_n(cs_n),
        .wr1_n(wr1_n), .wr2_n(wr2_n), .xfer_n(xfer_n), .ile(ile));

    // pulse log built from port observation
    int lg_cs [64]; int lg_data [64]; int lg_xfer [64]; int lg_kind [64];
    int lg_su [64]; int lg_w [64]; int lg_h [64];
    int log_n = 0, mph = 0, su = 0, w = 0, h = 0, kind = 0;
    int c_cs = 0, c_data = 0, c_xfer = 0;
    int viol = 0, done_n = 0, done_wide = 0;
    logic [NCH-1:0] prev_cs = '1;
    logic [DW-1:0]  prev_bus = '0;
    logic prev_done = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (dbus != prev_bus && !(&prev_cs)) viol++;
            if (done) done_n++;
            if (done && prev_done) done_wide++;
            case (mph)
                0: if (!(&cs_n)) begin
                       mph = 1; su = 1; c_cs = int'(cs_n); c_data = int'(dbus); c_xfer = int'(xfer_n);
                   end
                1: if (!wr1_n || !wr2_n) begin mph = 2; w = 1; kind = int'(!wr2_n); end
                   else su++;
                2: if (wr1_n && wr2_n) begin mph = 3; h = 1; end
                   else w++;
                default: if (&cs_n) begin
                       if (log_n < 64) begin
                           lg_cs[log_n] = c_cs; lg_data[log_n] = c_data; lg_xfer[log_n] = c_xfer;
                           lg_kind[log_n] = kind; lg_su[log_n] = su; lg_w[log_n] = w; lg_h[log_n] = h;
                       end
                       log_n++; mph = 0;
                   end else h++;
            endcase
        end
        prev_cs = cs_n; prev_bus = dbus; prev_done = done;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push_write(input int ch, input int dat);
        @(negedge clk); wr_req = 1'b1; wr_chan = 2'(ch); wr_data = DW'(dat);
        @(negedge clk); wr_req = 1'b0;
    endtask

    task automatic push_commit();
        @(negedge clk); commit_req = 1'b1;
        @(negedge clk); commit_req = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 5000) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    task automatic chk_entry(input int i, input string tag, input int cs, input int dat,
                             input int k, input int width);
        chk(lg_cs[i] == cs, {tag, " cs"}, lg_cs[i], cs);
        if (k == 0) chk(lg_data[i] == dat, {tag, " data"}, lg_data[i], dat);
        chk(lg_kind[i] == k, {tag, " kind"}, lg_kind[i], k);
        chk(lg_xfer[i] == (k ? 0 : 1), {tag, " xfer"}, lg_xfer[i], k ? 0 : 1);
        chk(lg_w[i] == width, {tag, " width"}, lg_w[i], width);
    endtask

    task automatic t_reset();
        chk(&cs_n && wr1_n && wr2_n && xfer_n, "R1 lines high", int'({cs_n, wr1_n, wr2_n, xfer_n}), 127);
        chk(ile == 1'b1, "R1 ile", int'(ile), 1);
        chk(dbus == '0 && !busy && !done && dirty == '0, "R1 status", int'({dbus, busy, done, dirty}), 0);
    endtask

    task automatic t_single_write();
        int b = log_n;
        push_write(2, 8'hA5);
        chk(busy == 1'b1, "R12 busy after request", int'(busy), 1);
        chk(dirty == '0, "R6 dirty before completion", int'(dirty), 0);
        wait_idle();
        chk(log_n == b + 1, "R2 one pulse", log_n, b + 1);
        chk_entry(b, "R2 write ch2", 4'b1011, 8'hA5, 0, SW);
        chk(lg_su[b] == SU, "R2 setup", lg_su[b], SU);
        chk(lg_w[b] == SW, "R3 strobe width", lg_w[b], SW);
        chk(lg_h[b] == HD, "R4 hold", lg_h[b], HD);
        chk(dirty == 4'b0100, "R6 dirty set", int'(dirty), 4);
        chk(!busy && &cs_n && wr1_n, "R11 idle rest", int'({busy, cs_n, wr1_n}), 31);
    endtask

    task automatic t_commit();
        int b = log_n, dn = done_n;
        push_commit();
        wait_idle();
        chk_entry(b, "R5 commit", 0, 0, 1, SW);
        chk(lg_su[b] == SU && lg_h[b] == HD, "R5 setup/hold", lg_su[b] * 100 + lg_h[b], SU * 100 + HD);
        chk(done_n == dn + 1, "R6 done once", done_n, dn + 1);
        chk(dirty == '0, "R6 dirty cleared", int'(dirty), 0);
    endtask

    task automatic t_empty_commit();
        int b = log_n, dn = done_n;
        push_commit();
        wait_idle();
        chk(log_n == b + 1, "R7 empty commit pulses", log_n, b + 1);
        chk(lg_kind[b] == 1 && lg_w[b] == SW, "R7 transfer pulse", lg_kind[b] * 1000 + lg_w[b], 1000 + SW);
        chk(done_n == dn + 1, "R7 done", done_n, dn + 1);
    endtask

    task automatic t_order();
        int b = log_n, dn = done_n;
        push_write(0, 8'h11);
        push_write(3, 8'h33);
        @(negedge clk); wr_req = 1'b1; wr_chan = 2'd1; wr_data = 8'h22; commit_req = 1'b1;
        @(negedge clk); wr_req = 1'b0; commit_req = 1'b0;
        wait_idle();
        chk(log_n == b + 4, "R9 four pulses", log_n, b + 4);
        chk_entry(b,     "R9 first ch0",  4'b1110, 8'h11, 0, SW);
        chk_entry(b + 1, "R9 second ch3", 4'b0111, 8'h33, 0, SW);
        chk_entry(b + 2, "R9 same-cycle load ch1", 4'b1101, 8'h22, 0, SW);
        chk_entry(b + 3, "R9 commit last", 0, 0, 1, SW);
        chk(done_n == dn + 1 && dirty == '0, "R9 commit covered load", done_n - dn, 1);
    endtask

    task automatic t_freeze_idle();
        int b = log_n;
        @(negedge clk); freeze = 1'b1;
        push_write(2, 8'h5A);
        repeat (20) @(negedge clk);
        chk(ile == 1'b0, "R8 ile low", int'(ile), 0);
        chk(wr1_n && &cs_n, "R8 no start", int'({wr1_n, cs_n}), 31);
        chk(busy == 1'b1 && log_n == b, "R8 queued", log_n - b, 0);
        freeze = 1'b0;
        wait_idle();
        chk(ile == 1'b1, "R8 ile restored", int'(ile), 1);
        chk_entry(b, "R8 deferred load", 4'b1011, 8'h5A, 0, SW);
    endtask

    task automatic t_freeze_mid();
        int b = log_n;
        push_write(1, 8'hC3);
        while (wr1_n) @(negedge clk);
        freeze = 1'b1;
        repeat (30) @(negedge clk);
        chk(wr1_n == 1'b0 && ile == 1'b0, "R8 strobe held", int'({wr1_n, ile}), 0);
        freeze = 1'b0;
        wait_idle();
        chk(lg_w[b] == SW + 30, "R8 stretched width", lg_w[b], SW + 30);
        chk(lg_h[b] == HD, "R4 hold after stall", lg_h[b], HD);
    endtask

    task automatic t_overflow();
        int b = log_n;
        @(negedge clk); freeze = 1'b1;
        for (int i = 0; i < QD + 1; i++) push_write(i % NCH, i + 1);
        freeze = 1'b0;
        wait_idle();
        chk(log_n == b + QD, "R10 excess dropped", log_n - b, QD);
        chk(lg_data[b + QD - 1] == QD, "R10 last kept", lg_data[b + QD - 1], QD);
        push_commit();
        wait_idle();
        chk(dirty == '0, "R10 cleanup", int'(dirty), 0);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_write();
        t_commit();
        t_empty_commit();
        t_order();
        t_freeze_idle();
        t_freeze_mid();
        t_overflow();
        chk(viol == 0, "R11 bus moved under select", viol, 0);
        chk(done_wide == 0, "R6 done width", done_wide, 0);
        fin = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule